// File: doc/BRIEF.md
# Virtual Partition ID Translator

This block converts guest-visible partition identifiers into physical partition identifiers. Two requesters share one mapping table. The kernel-level requester presents one partition ID and the user-level requester presents another. Each requester has its own translation enable. When its enable is set, the requester's ID selects a 16-bit physical ID from the table. When its enable is clear, the ID passes through unchanged.

The hypervisor programs the table through a simple register port. The port carries up to eight 64-bit mapping words, a 32-bit valid mask and a control register that holds the two enables. The number of implemented words is a parameter. Each word packs four entries. Both lookups are combinational from the stored state. Each lookup returns the physical ID, a flag saying translation was applied and a flag saying the selected entry was not valid.

Top module: `vpid_translator`

## Requirements
- R1: After reset, every mapping word, the valid mask and both enables read as zero, and both lookups pass their IDs through untranslated.
- R2: Virtual ID 4k+j uses bits [16j+15:16j] of mapping word k.
- R3: The entry for virtual ID n is valid only when bit n of the valid mask is 1.
- R4: Control bit 0 enables translation of the kernel-level ID. This bit has no effect on the user-level lookup.
- R5: Control bit 1 enables translation of the user-level ID. This bit has no effect on the kernel-level lookup.
- R6: With its enable at 0, a lookup outputs its input ID unchanged, with translated=0 and invalid=0.
- R7: With its enable at 1, a lookup always reports translated=1. If the selected entry is invalid, the lookup outputs physical ID 0 with invalid=1.
- R8: Addresses 0 to 7 select mapping words. An address above the MAX_IDX parameter reads as zero and ignores writes, and the implemented words are left unchanged.
- R9: With translation enabled, a virtual ID of 4*(MAX_IDX+1) or more is reported as invalid.
- R10: A write updates a whole 64-bit word. Reads and lookups see the new value from the cycle after the write is accepted.
- R11: Address 8 is the valid mask (low 32 bits; upper write bits are dropped) and address 9 is control. Any other address from 10 to 15 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Combinational read data for addr |
| kVid | input | 16 | Kernel-level virtual partition ID |
| uVid | input | 16 | User-level virtual partition ID |
| kPid | output | 16 | Kernel-level physical partition ID |
| kTranslated | output | 1 | Kernel lookup used the table |
| kInvalid | output | 1 | Kernel lookup hit an invalid or absent entry |
| uPid | output | 16 | User-level physical partition ID |
| uTranslated | output | 1 | User lookup used the table |
| uInvalid | output | 1 | User lookup hit an invalid or absent entry |

## Verification
A write commits at the clock edge where wrEn is high. Read data and both lookup results are combinational from the stored state, so they are due in the same cycle the inputs change, and a write becomes visible one edge after it is accepted. The driver changes inputs only between edges. Each write is completed across one rising edge before the driver queues expected values. The monitor compares those values a short delay later, while no write is pending, so every sample falls in a settled window between edges.

// File: rtl/vpid_pkg.sv
package vpid_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 4'd9;

  typedef enum logic [1:0] {RD_ZERO, RD_MAP, RD_MASK, RD_CTL} rdKind_e;

  typedef struct packed {
    logic       wrMap;
    logic       wrMask;
    logic       wrCtl;
    logic [2:0] mapIdx;
    rdKind_e    rdKind;
  } strobe_t;
endpackage

// File: rtl/vpid_ctrl.sv
module vpid_ctrl
  import vpid_pkg::*;
#(
  parameter int MAX_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);
  always_comb begin
    strb        = '0;
    strb.mapIdx = addr[2:0];
    strb.rdKind = RD_ZERO;
    if (!addr[3]) begin
      if (int'(addr) <= MAX_IDX) begin
        strb.rdKind = RD_MAP;
        strb.wrMap  = wrEn;
      end
    end else if (addr == ADDR_MASK) begin
      strb.rdKind = RD_MASK;
      strb.wrMask = wrEn;
    end else if (addr == ADDR_CTL) begin
      strb.rdKind = RD_CTL;
      strb.wrCtl  = wrEn;
    end
  end

  AST_ABSENT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr[3] && int'(addr) > MAX_IDX) |-> !strb.wrMap); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.wrMap, strb.wrMask, strb.wrCtl}) <= 1); // R11
endmodule

// File: rtl/vpid_lookup.sv
module vpid_lookup #(
  parameter int ID_W    = 16,
  parameter int NUM_IDS = 16,
  parameter int MASK_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    en,
  input  logic [ID_W-1:0]         vid,
  input  logic [NUM_IDS*ID_W-1:0] entryFlat,
  input  logic [MASK_W-1:0]       mask,
  output logic [ID_W-1:0]         pid,
  output logic                    translated,
  output logic                    invalid
);
  localparam int SLOT_W = $clog2(NUM_IDS);
  localparam int PAD    = 1 << SLOT_W;

  logic [ID_W-1:0]   entryTab [PAD];
  logic [SLOT_W-1:0] slot;
  logic              inRange;
  logic              hit;

  for (genvar s = 0; s < PAD; s++) begin : g_tab
    if (s < NUM_IDS) begin : g_real
      assign entryTab[s] = entryFlat[s*ID_W +: ID_W];
    end else begin : g_pad
      assign entryTab[s] = '0;
    end
  end

  assign slot    = vid[SLOT_W-1:0];
  assign inRange = 32'(vid) < 32'(NUM_IDS);
  assign hit     = inRange && mask[slot];

  always_comb begin
    pid        = vid;
    translated = 1'b0;
    invalid    = 1'b0;
    if (en) begin
      translated = 1'b1;
      invalid    = !hit;
      pid        = hit ? entryTab[slot] : '0;
    end
  end

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> (pid == vid && !translated && !invalid)); // R6
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    invalid |-> (pid == '0 && translated)); // R7
  AST_RANGE_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (en && 32'(vid) >= 32'(NUM_IDS)) |-> invalid); // R9
endmodule

// File: rtl/vpid_datapath.sv
module vpid_datapath
  import vpid_pkg::*;
#(
  parameter int MAX_IDX = 3,
  parameter int ID_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [4*ID_W-1:0]   wrData,
  output logic [4*ID_W-1:0]   rdData,
  input  logic [ID_W-1:0]     kVid,
  input  logic [ID_W-1:0]     uVid,
  output logic [ID_W-1:0]     kPid,
  output logic                kTranslated,
  output logic                kInvalid,
  output logic [ID_W-1:0]     uPid,
  output logic                uTranslated,
  output logic                uInvalid
);
  localparam int NUM_WORDS = MAX_IDX + 1;
  localparam int WORD_W    = 4 * ID_W;
  localparam int NUM_IDS   = 4 * NUM_WORDS;
  localparam int MASK_W    = 32;

  logic [WORD_W-1:0]         mapWord [8];
  logic [NUM_IDS*ID_W-1:0]   entryFlat;
  logic [MASK_W-1:0]         validMask;
  logic                      kEn;
  logic                      uEn;

  for (genvar w = 0; w < 8; w++) begin : g_word
    if (w < NUM_WORDS) begin : g_impl
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strb.wrMap && strb.mapIdx == 3'(w)) q <= wrData;
      end
      assign mapWord[w] = q;
      assign entryFlat[w*WORD_W +: WORD_W] = q;
    end else begin : g_absent
      assign mapWord[w] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      kEn       <= 1'b0;
      uEn       <= 1'b0;
    end else begin
      if (strb.wrMask) validMask <= wrData[MASK_W-1:0];
      if (strb.wrCtl) begin
        kEn <= wrData[0];
        uEn <= wrData[1];
      end
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_MAP:  rdData = mapWord[strb.mapIdx];
      RD_MASK: rdData = WORD_W'(validMask);
      RD_CTL:  rdData = WORD_W'({uEn, kEn});
      default: rdData = '0;
    endcase
  end

  vpid_lookup #(.ID_W(ID_W), .NUM_IDS(NUM_IDS), .MASK_W(MASK_W)) u_kLook (
    .clk(clk), .rstN(rstN), .en(kEn), .vid(kVid), .entryFlat(entryFlat),
    .mask(validMask), .pid(kPid), .translated(kTranslated), .invalid(kInvalid)
  );

  vpid_lookup #(.ID_W(ID_W), .NUM_IDS(NUM_IDS), .MASK_W(MASK_W)) u_uLook (
    .clk(clk), .rstN(rstN), .en(uEn), .vid(uVid), .entryFlat(entryFlat),
    .mask(validMask), .pid(uPid), .translated(uTranslated), .invalid(uInvalid)
  );

  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMap |=> mapWord[$past(strb.mapIdx)] == $past(wrData)); // R10
  AST_MASK_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> validMask == $past(wrData[MASK_W-1:0])); // R11
endmodule

// File: rtl/vpid_translator.sv
module vpid_translator
  import vpid_pkg::*;
#(
  parameter int MAX_IDX = 3,
  parameter int ID_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        addr,
  input  logic [63:0]       wrData,
  output logic [63:0]       rdData,
  input  logic [15:0]       kVid,
  input  logic [15:0]       uVid,
  output logic [15:0]       kPid,
  output logic              kTranslated,
  output logic              kInvalid,
  output logic [15:0]       uPid,
  output logic              uTranslated,
  output logic              uInvalid
);
  strobe_t strb;

  vpid_ctrl #(.MAX_IDX(MAX_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  vpid_datapath #(.MAX_IDX(MAX_IDX), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .kVid(kVid), .uVid(uVid),
    .kPid(kPid), .kTranslated(kTranslated), .kInvalid(kInvalid),
    .uPid(uPid), .uTranslated(uTranslated), .uInvalid(uInvalid)
  );
endmodule

// File: tb/vpid_translator_tb.sv
module vpid_translator_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic [15:0] kVid = '0;
  logic [15:0] uVid = '0;
  logic [15:0] kPid;
  logic [15:0] uPid;
  logic        kTranslated, kInvalid, uTranslated, uInvalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vpid_translator u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .kVid(kVid), .uVid(uVid),
    .kPid(kPid), .kTranslated(kTranslated), .kInvalid(kInvalid),
    .uPid(uPid), .uTranslated(uTranslated), .uInvalid(uInvalid)
  );

  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  event  chk;
  event  chkDone;

  function automatic logic [63:0] pick(int sel);
    case (sel)
      0: return rdData;
      1: return 64'(kPid);
      2: return 64'(kTranslated);
      3: return 64'(kInvalid);
      4: return 64'(uPid);
      5: return 64'(uTranslated);
      default: return 64'(uInvalid);
    endcase
  endfunction

  // monitor
  initial begin
    forever begin
      @(chk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = sbq.pop_front();
        act = pick(it.sel);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
      ->chkDone;
    end
  end

  task automatic want(int sel, logic [63:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic flush();
    ->chk;
    @(chkDone);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic look(logic [3:0] a, logic [15:0] k, logic [15:0] u);
    addr = a; kVid = k; uVid = u;
    #2;
  endtask

  task automatic wantK(logic [15:0] p, bit t, bit i, string tag);
    want(1, 64'(p), tag); want(2, 64'(t), tag); want(3, 64'(i), tag);
  endtask

  task automatic wantU(logic [15:0] p, bit t, bit i, string tag);
    want(4, 64'(p), tag); want(5, 64'(t), tag); want(6, 64'(i), tag);
  endtask

  localparam logic [63:0] W0 = 64'h0A03_0A02_0A01_0A00;
  localparam logic [63:0] W1 = 64'h7777_6666_5555_4444;
  localparam logic [63:0] W3 = 64'hD3D3_C2C2_B1B1_A0A0;

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1: reset state
    look(4'd0, 16'd5, 16'd9);
    want(0, 64'd0, "R1 word0"); wantK(16'd5, 0, 0, "R1 kpass"); wantU(16'd9, 0, 0, "R1 upass");
    flush();
    look(4'd8, 16'd5, 16'd9); want(0, 64'd0, "R1 mask"); flush();
    look(4'd9, 16'd5, 16'd9); want(0, 64'd0, "R1 ctl"); flush();

    // R10 / R2: whole-word writes visible next cycle
    wr(4'd1, W1);
    look(4'd1, 16'd0, 16'd0); want(0, W1, "R10 word1 readback"); flush();
    wr(4'd0, W0);
    wr(4'd3, W3);
    look(4'd3, 16'd0, 16'd0); want(0, W3, "R10 word3 readback"); flush();

    // R11: mask drops upper bits; control readback
    wr(4'd8, 64'hFFFF_FFFF_0000_80F2);
    look(4'd8, 16'd0, 16'd0); want(0, 64'h80F2, "R11 mask low bits"); flush();
    wr(4'd9, 64'd1);
    look(4'd9, 16'd0, 16'd0); want(0, 64'd1, "R11 ctl"); flush();

    // R2 / R4 / R5: kernel enabled only
    look(4'd0, 16'd6, 16'd6);
    wantK(16'h6666, 1, 0, "R2 vid6"); wantU(16'd6, 0, 0, "R5 user off"); flush();
    look(4'd0, 16'd1, 16'd4);
    wantK(16'h0A01, 1, 0, "R2 vid1"); wantU(16'd4, 0, 0, "R6 pass"); flush();
    look(4'd0, 16'd15, 16'd0);
    wantK(16'hD3D3, 1, 0, "R2 vid15"); flush();

    // R3 / R7: invalid entry
    look(4'd0, 16'd0, 16'd0); wantK(16'd0, 1, 1, "R3 R7 vid0 masked"); flush();
    look(4'd0, 16'd12, 16'd0); wantK(16'd0, 1, 1, "R3 vid12 masked"); flush();

    // R9: beyond implemented range
    look(4'd0, 16'd16, 16'd0); wantK(16'd0, 1, 1, "R9 vid16"); flush();
    look(4'd0, 16'd40, 16'd0); wantK(16'd0, 1, 1, "R9 vid40"); flush();

    // R4 / R5: user enabled only
    wr(4'd9, 64'd2);
    look(4'd0, 16'd6, 16'd4);
    wantK(16'd6, 0, 0, "R4 kernel off"); wantU(16'h4444, 1, 0, "R5 user on"); flush();
    look(4'd0, 16'd6, 16'd20); wantU(16'd0, 1, 1, "R9 user vid20"); flush();

    // R8: absent words
    wr(4'd5, 64'hDEAD_BEEF_DEAD_BEEF);
    look(4'd5, 16'd0, 16'd0); want(0, 64'd0, "R8 word5 reads zero"); flush();
    look(4'd6, 16'd0, 16'd0); want(0, 64'd0, "R8 word6 reads zero"); flush();
    look(4'd1, 16'd0, 16'd5);
    want(0, W1, "R8 word1 unchanged"); wantU(16'h5555, 1, 0, "R8 lookup unchanged"); flush();

    // R11: unused address
    wr(4'd12, 64'h1234);
    look(4'd12, 16'd0, 16'd0); want(0, 64'd0, "R11 addr12 zero"); flush();
    look(4'd9, 16'd0, 16'd0); want(0, 64'd2, "R11 ctl unchanged"); flush();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule